// File: doc/BRIEF.md
# Configurable-Aspect 4 Kbit Embedded RAM

This block is a 4096-bit synchronous memory. It has one write port and one read port, and these ports work independently. A static configuration input sets how the fixed bit store is split into words. The choices are 256 words of 16 bits, 512 of 8, 1024 of 4 or 2048 of 2. Every configuration uses the whole store. Each word sits at a fixed linear bit position, so data written in one organisation can be read back in another organisation at the same bit positions.

The write address, write data and write enable are captured on the input clock. The array is updated on the following input-clock edge. A clock-select input chooses whether the read address and read enable are captured on the input clock or the output clock. The array output can then pass through an output register clocked by the output clock, or bypass it.

To get a wider memory, place two instances side by side. They share the addresses, enables and configuration, and each one takes half of the data bus. Two 512x8 instances make a 512x16 memory, and two 256x16 instances make a 256x32 memory.

Top module: `cfg_ram_4k`

## Requirements
- R1: `mode_i` selects the organisation: 0 = 256x16, 1 = 512x8, 2 = 1024x4, 3 = 2048x2. In every mode, word A with width W occupies store bits A*W to A*W+W-1, and it maps to the low W bits of the data buses.
- R2: Data written in one mode reads back in any other mode from the matching bit positions. For example, after writing 16'hA5C3 to address 0 in mode 0, a mode-1 read of address 1 returns 16'h00A5.
- R3: In narrow modes, the write ignores address bits above the mode's word count and data bits above the word width. The unused upper bits of `rd_data_o` read as zero.
- R4: A write presented with `wr_en_i` high at input-clock edge N is captured in registers. It updates the store at edge N+1.
- R5: A narrow write changes only its own W bits. All other bits of the store keep their values.
- R6: The read address and read enable are captured on `clk_in_i` when `rd_clk_sel_i` is 0, and on `clk_out_i` when it is 1. With the selected clock stopped, new read addresses have no effect.
- R7: With `out_reg_en_i` = 1, the output register loads the array output on a `clk_out_i` edge at which the captured read enable is high. Read data therefore appears after the second edge. With `out_reg_en_i` = 0, data appears right after the read-address register updates.
- R8: A registered read of the address being written, with both presented in the same cycle, returns the data from before the write.
- R9: While `rd_en_i` is low, the read-address register holds its value. While the captured read enable is low, the output register holds its value. Either way, `rd_data_o` does not change.
- R10: Reset (`rst_ni` low) clears all pipeline registers. With the output register selected, `rd_data_o` then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in_i | input | 1 | Write clock; optional read-address clock |
| clk_out_i | input | 1 | Output-register clock; optional read-address clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Word organisation select |
| rd_clk_sel_i | input | 1 | Read-address clock: 0 input clock, 1 output clock |
| out_reg_en_i | input | 1 | 1 registered output, 0 combinational output |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 11 | Write word address |
| wr_data_i | input | 16 | Write data, low bits used in narrow modes |
| rd_en_i | input | 1 | Read enable |
| rd_addr_i | input | 11 | Read word address |
| rd_data_o | output | 16 | Read data |

## Verification
The assertions assume a few things about the inputs:
- `mode_i`, `rd_clk_sel_i` and `out_reg_en_i` change only between accesses, never while a write or read is still in the pipeline.
- Any stopped clock is gated cleanly while low.

The stimulus respects these limits. It changes configuration and gates `clk_out_i` only on falling edges of the input clock, and only after the previous write has reached the store. It also writes every word before reading it, so no read sees an uninitialised bit.

// File: rtl/cfg_ram_pkg.sv
package cfg_ram_pkg;
  localparam int RAM_BITS  = 4096;
  localparam int RAM_MAX_W = 16;

  typedef enum logic [1:0] {
    MODE_X16 = 2'd0,
    MODE_X8  = 2'd1,
    MODE_X4  = 2'd2,
    MODE_X2  = 2'd3
  } aspect_e;
endpackage

// File: rtl/cfg_ram_wr_stage.sv
module cfg_ram_wr_stage
  import cfg_ram_pkg::*;
#(
  parameter int MAXW = RAM_MAX_W,
  parameter int AW   = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [MAXW-1:0] wr_data_i,
  output logic            we_q_o,
  output logic [AW-1:0]   waddr_q_o,
  output logic [MAXW-1:0] wdata_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q_o    <= 1'b0;
      waddr_q_o <= '0;
      wdata_q_o <= '0;
    end else begin
      we_q_o    <= wr_en_i;
      waddr_q_o <= wr_addr_i;
      wdata_q_o <= wr_data_i;
    end
  end

  // R4
  wr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (we_q_o && wdata_q_o == $past(wr_data_i)));
endmodule

// File: rtl/cfg_ram_store.sv
module cfg_ram_store
  import cfg_ram_pkg::*;
#(
  parameter int BITS = RAM_BITS,
  parameter int MAXW = RAM_MAX_W,
  parameter int AW   = 11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  aspect_e         mode_i,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [MAXW-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [MAXW-1:0] rdata_o
);
  localparam int BW        = $clog2(BITS);
  localparam int WW        = $clog2(MAXW);
  localparam int MIN_WORDS = BITS / MAXW;

  logic [BITS-1:0] mem_q;
  logic [BITS-1:0] wmask, wval;
  logic [MAXW-1:0] lane;
  logic [AW-1:0]   amask;
  logic [BW-1:0]   wbase, rbase;
  int unsigned     shift;

  always_comb begin
    shift = WW - int'(mode_i);
    lane  = {MAXW{1'b1}} >> (MAXW - (MAXW >> mode_i));
    amask = AW'((MIN_WORDS << mode_i) - 1);
    wbase = BW'(waddr_i & amask) << shift;
    rbase = BW'(raddr_i & amask) << shift;
    wmask = {{(BITS-MAXW){1'b0}}, lane} << wbase;
    wval  = {{(BITS-MAXW){1'b0}}, wdata_i & lane} << wbase;
    rdata_o = MAXW'(mem_q >> rbase) & lane;
  end

  // Storage is not reset: contents are undefined until written.
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q <= (mem_q & ~wmask) | wval;
  end

  // R3
  narrow_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_X2) |-> ((rdata_o >> (MAXW >> 3)) == '0));
endmodule

// File: rtl/cfg_ram_rd_stage.sv
module cfg_ram_rd_stage
  import cfg_ram_pkg::*;
#(
  parameter int MAXW = RAM_MAX_W,
  parameter int AW   = 11
) (
  input  logic            clk_in_i,
  input  logic            clk_out_i,
  input  logic            rst_ni,
  input  logic            rd_clk_sel_i,
  input  logic            out_reg_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [AW-1:0]   raddr_q_o,
  input  logic [MAXW-1:0] arr_data_i,
  output logic [MAXW-1:0] rd_data_o
);
  logic            rd_clk;
  logic            ren_q;
  logic [MAXW-1:0] dout_q;

  // Static select; switched only while both clocks are low.
  assign rd_clk = rd_clk_sel_i ? clk_out_i : clk_in_i;

  always_ff @(posedge rd_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ren_q     <= 1'b0;
      raddr_q_o <= '0;
    end else begin
      ren_q <= rd_en_i;
      if (rd_en_i) raddr_q_o <= rd_addr_i;
    end
  end

  always_ff @(posedge clk_out_i or negedge rst_ni) begin
    if (!rst_ni)    dout_q <= '0;
    else if (ren_q) dout_q <= arr_data_i;
  end

  assign rd_data_o = out_reg_en_i ? dout_q : arr_data_i;

  // R9
  raddr_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_ni)
    !rd_en_i |=> $stable(raddr_q_o));

  // R9
  dout_hold_chk: assert property (@(posedge clk_out_i) disable iff (!rst_ni)
    !ren_q |=> $stable(dout_q));
endmodule

// File: rtl/cfg_ram_4k.sv
module cfg_ram_4k
  import cfg_ram_pkg::*;
#(
  parameter int BITS = RAM_BITS,
  parameter int MAXW = RAM_MAX_W,
  localparam int AW  = $clog2(BITS / 2)
) (
  input  logic            clk_in_i,
  input  logic            clk_out_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic            rd_clk_sel_i,
  input  logic            out_reg_en_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [MAXW-1:0] wr_data_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [MAXW-1:0] rd_data_o
);
  logic            we_q;
  logic [AW-1:0]   waddr_q, raddr_q;
  logic [MAXW-1:0] wdata_q, arr_data;

  cfg_ram_wr_stage #(.MAXW(MAXW), .AW(AW)) u_wr (
    .clk_i    (clk_in_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .we_q_o   (we_q),
    .waddr_q_o(waddr_q),
    .wdata_q_o(wdata_q)
  );

  cfg_ram_store #(.BITS(BITS), .MAXW(MAXW), .AW(AW)) u_store (
    .clk_i  (clk_in_i),
    .rst_ni (rst_ni),
    .mode_i (aspect_e'(mode_i)),
    .we_i   (we_q),
    .waddr_i(waddr_q),
    .wdata_i(wdata_q),
    .raddr_i(raddr_q),
    .rdata_o(arr_data)
  );

  cfg_ram_rd_stage #(.MAXW(MAXW), .AW(AW)) u_rd (
    .clk_in_i    (clk_in_i),
    .clk_out_i   (clk_out_i),
    .rst_ni      (rst_ni),
    .rd_clk_sel_i(rd_clk_sel_i),
    .out_reg_en_i(out_reg_en_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .raddr_q_o   (raddr_q),
    .arr_data_i  (arr_data),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: tb/cfg_ram_4k_tb_top.sv
`timescale 1ns/1ps
module cfg_ram_4k_tb_top;
  logic        clk = 1'b0;
  logic        out_run = 1'b1;
  logic        clk_out;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        rd_clk_sel = 1'b0;
  logic        out_reg_en = 1'b1;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [10:0] rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign clk_out = clk & out_run;

  cfg_ram_4k dut_i (
    .clk_in_i(clk), .clk_out_i(clk_out), .rst_ni(rst_n), .mode_i(mode),
    .rd_clk_sel_i(rd_clk_sel), .out_reg_en_i(out_reg_en),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        is_wr;
    logic [10:0] addr;
    logic [15:0] data;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 11'h000, 16'hA5C3},  // R1 wide write
    '{2'd1, 1'b0, 11'h000, 16'h00C3},  // R2
    '{2'd1, 1'b0, 11'h001, 16'h00A5},  // R2
    '{2'd3, 1'b0, 11'h000, 16'h0003},  // R2 R3
    '{2'd3, 1'b0, 11'h001, 16'h0000},  // R2
    '{2'd3, 1'b0, 11'h003, 16'h0003},  // R2
    '{2'd2, 1'b0, 11'h003, 16'h000A},  // R2
    '{2'd2, 1'b1, 11'h001, 16'hFFF7},  // R3 R5 upper data ignored
    '{2'd0, 1'b0, 11'h000, 16'hA573},  // R5
    '{2'd0, 1'b1, 11'h105, 16'h1234},  // R3 upper address ignored
    '{2'd0, 1'b0, 11'h005, 16'h1234},  // R3
    '{2'd0, 1'b1, 11'h0FF, 16'h0000},  // R1
    '{2'd3, 1'b1, 11'h7FF, 16'hFFFE},  // R1 top word
    '{2'd0, 1'b0, 11'h0FF, 16'h8000},  // R1 R5
    '{2'd1, 1'b1, 11'h1FF, 16'h005A},  // R1
    '{2'd0, 1'b0, 11'h0FF, 16'h5A00}   // R2
  };

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [10:0] a);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data, 16'h0000, "R10 reset output");
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data, 16'h0000, "R10 after release");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); mode = VECS[i].mode;
      if (VECS[i].is_wr) do_write(VECS[i].addr, VECS[i].data);
      else begin
        do_read(VECS[i].addr);
        check(rd_data, VECS[i].data, $sformatf("R1/R2/R3/R5 vector %0d", i));
      end
    end

    // R8 read of the address being written returns old data
    mode = 2'd0;
    do_write(11'h010, 16'h1111);
    @(negedge clk); wr_en = 1'b1; wr_addr = 11'h010; wr_data = 16'h2222;
                    rd_en = 1'b1; rd_addr = 11'h010;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk); check(rd_data, 16'h1111, "R8 old data");
    @(negedge clk); check(rd_data, 16'h1111, "R9 output held");
    do_read(11'h010);
    check(rd_data, 16'h2222, "R4 R8 new data");

    // R9 read enable low holds registered and bypass outputs
    do_read(11'h005);
    check(rd_data, 16'h1234, "R9 setup");
    @(negedge clk); rd_addr = 11'h000;
    repeat (3) @(negedge clk);
    check(rd_data, 16'h1234, "R9 registered hold");
    out_reg_en = 1'b0;
    #1 check(rd_data, 16'h1234, "R9 bypass shows held address");
    repeat (2) @(negedge clk);
    check(rd_data, 16'h1234, "R9 bypass hold");

    // R7 bypass latency: one edge
    @(negedge clk); rd_en = 1'b1; rd_addr = 11'h000;
    @(negedge clk); rd_en = 1'b0;
    check(rd_data, 16'hA573, "R7 bypass one edge");
    // R7 registered latency: two edges
    out_reg_en = 1'b1; rd_en = 1'b1; rd_addr = 11'h005;
    @(negedge clk); rd_en = 1'b0;
    check(rd_data, 16'hA573, "R7 registered not yet");
    @(negedge clk);
    check(rd_data, 16'h1234, "R7 registered two edges");

    // R6 read clock selection, bypass output
    out_reg_en = 1'b0; out_run = 1'b0; rd_clk_sel = 1'b0;
    @(negedge clk); rd_en = 1'b1; rd_addr = 11'h000;
    @(negedge clk); rd_en = 1'b0;
    check(rd_data, 16'hA573, "R6 input clock captures");
    rd_clk_sel = 1'b1;
    @(negedge clk); rd_en = 1'b1; rd_addr = 11'h005;
    repeat (2) @(negedge clk);
    check(rd_data, 16'hA573, "R6 stopped output clock ignores");
    out_run = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check(rd_data, 16'h1234, "R6 output clock captures");
    rd_clk_sel = 1'b0; out_reg_en = 1'b1;

    // R10 reset mid-run clears output register
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check(rd_data, 16'h0000, "R10 mid-run reset");
    rst_n = 1'b1;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule